// File: doc/BRIEF.md
# Node Instruction Source and Execute-Mask Controller

Each processing node of a mesh array contains this controller. On every cycle it decides where the node's next instruction comes from and whether the node executes it. A one-bit mode register selects the source. In SIMD mode the node takes the instruction word that a global sequencer broadcasts. In MIMD mode it fetches from its own local program memory, using a local program counter. The controller carries out the switch in both directions, and registers and memories keep their contents across a switch.

Each instruction is checked against an execute mask before it takes effect. One bit of the instruction chooses the source of the mask. The first source is a comparison of the instruction's 7-bit ID field with the node's ID, where the all-ones value addresses every node. The second source is a one-bit local mask register, which an instruction can write. A level Standby input pauses the node, and releasing it resumes execution with no instruction lost or repeated.

The broadcast input is a valid/ready stream. The sequencer holds `bcast_valid` and `bcast_instr` steady until `bcast_ready` is high at a clock edge. `bcast_ready` is high only in SIMD mode while Standby is low. The issue output carries no back-pressure: the execution units take every word that has `issue_valid` high. Entering MIMD takes two broadcast instructions after the program has been loaded: a jump-immediate to the start address, then a mode-set.

Top module: `node_seq_ctrl`

## Requirements
- R1: After reset the node is in SIMD mode (`mimd_mode`=0), the local program counter is 0, the local mask bit is 1, `issue_valid` and `lpm_rd_en` are 0, and `bcast_ready` is 1 while `standby` is low.
- R2: In SIMD mode a broadcast word is accepted in a cycle where `bcast_valid` and `bcast_ready` are both high, and it appears on `issue_instr` with `issue_valid`=1 in that same cycle. In MIMD mode `bcast_ready` stays 0.
- R3: With instruction bit 7 at 0 (ID masking), a SIMD instruction executes (`issue_exec`=1) exactly when bits [6:0] equal `node_id` or equal 7'h7F.
- R4: With instruction bit 7 at 1 (local masking), a SIMD instruction executes exactly when the local mask bit is 1. The opcode 6'h3D in bits [31:26] writes bit 8 of the instruction into the local mask bit when it executes.
- R5: An instruction that does not execute changes no state: a masked mask-write, mode-set or jump leaves the mask bit, the mode and the counter unchanged.
- R6: The opcode 6'h10 (jump-immediate) loads the 11-bit target in bits [18:8] into the local program counter when it executes, in either mode.
- R7: The opcode 6'h3E (mode-set) loads bit 8 into the mode register when it executes (0 selects SIMD, 1 selects MIMD). The new mode takes effect in the cycle after the instruction is issued.
- R8: In MIMD mode with Standby low, the node drives `lpm_rd_en`=1 and `lpm_addr` equal to the counter, and then increments the counter. The word read is issued in the next cycle with `issue_exec`=1, and consecutive addresses are issued in order.
- R9: When an executed jump-immediate is issued in MIMD mode, the word fetched in that cycle is discarded, and the next word issued is the one at the target address.
- R10: When an executed mode-set to 0 is issued in MIMD mode, the fetch in flight is discarded, and `bcast_ready` is 1 in the next cycle (with Standby low).
- R11: While `standby` is 1, no broadcast word is accepted, `issue_valid` and `lpm_rd_en` are 0, and a fetch in flight is rewound. After release the MIMD stream continues with no word lost or duplicated, and a held broadcast word is accepted exactly once.
- R12: The local mask bit keeps its value across a switch to MIMD and back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 7 | This node's ID |
| standby | input | 1 | Pause while high |
| bcast_valid | input | 1 | Broadcast word present |
| bcast_ready | output | 1 | Node accepts the broadcast word |
| bcast_instr | input | 32 | Broadcast instruction word |
| lpm_rd_en | output | 1 | Local program memory read strobe |
| lpm_addr | output | 11 | Local program memory read address |
| lpm_rdata | input | 32 | Read data, one cycle after the strobe |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_instr | output | 32 | The issued instruction |
| issue_exec | output | 1 | The issued instruction passes its mask |
| mimd_mode | output | 1 | Mode register: 0 SIMD, 1 MIMD |

## Verification
The assertions assume three things about the inputs. The program memory returns its data exactly one cycle after a strobe. `bcast_instr` is stable while `bcast_valid` waits for ready. `node_id` does not change after reset. The bench models the memory as a synchronous array that it reads at the clock edge. It changes broadcast inputs only at falling edges, holds each word until it is accepted, and keeps `node_id` constant at 7'h05.

// File: rtl/node_ctl_pkg.sv
package node_ctl_pkg;
  localparam int INSTR_W  = 32;
  localparam int OPC_LSB  = 26;
  localparam int OPC_W    = 6;
  localparam int ARG_LSB  = 8;
  localparam int MSEL_BIT = 7;

  localparam logic [OPC_W-1:0] OPC_JUMPI   = 6'h10;
  localparam logic [OPC_W-1:0] OPC_SETMASK = 6'h3D;
  localparam logic [OPC_W-1:0] OPC_CONFIG  = 6'h3E;

  typedef enum logic {
    MODE_SIMD = 1'b0,
    MODE_MIMD = 1'b1
  } node_mode_e;
endpackage

// File: rtl/node_mask_eval.sv
module node_mask_eval #(
  parameter int ID_W = 7
) (
  input  logic [ID_W-1:0] id_field,
  input  logic            sel_local,
  input  logic [ID_W-1:0] node_id,
  input  logic            lmask,
  output logic            hit
);
  localparam logic [ID_W-1:0] ID_ALL = '1;

  logic id_hit;

  always_comb begin
    id_hit = (id_field == node_id) || (id_field == ID_ALL);
    hit    = sel_local ? lmask : id_hit;
  end
endmodule

// File: rtl/node_mode_reg.sv
module node_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_val,
  input  logic msk_we,
  input  logic msk_val,
  output logic mode_q,
  output logic lmask_q
);
  import node_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_SIMD;
      lmask_q <= 1'b1;
    end else begin
      if (cfg_we) mode_q  <= cfg_val;
      if (msk_we) lmask_q <= msk_val;
    end
  end

  // R7
  mode_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(cfg_we));

  // R5
  mask_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lmask_q) |-> $past(msk_we));
endmodule

// File: rtl/node_local_fetch.sv
module node_local_fetch #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_q,
  input  logic            standby,
  input  logic            jump_req,
  input  logic [PC_W-1:0] jump_tgt,
  input  logic            mode_chg,
  output logic            lpm_rd_en,
  output logic [PC_W-1:0] lpm_addr,
  output logic            pend_q
);
  logic [PC_W-1:0] lpc_q;
  logic [PC_W-1:0] pend_addr_q;
  logic            fetch_now;

  always_comb begin
    fetch_now = mode_q && !standby;
    lpm_rd_en = fetch_now;
    lpm_addr  = lpc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lpc_q       <= '0;
      pend_addr_q <= '0;
      pend_q      <= 1'b0;
    end else if (standby) begin
      if (pend_q) lpc_q <= pend_addr_q;
      pend_q <= 1'b0;
    end else if (jump_req) begin
      lpc_q  <= jump_tgt;
      pend_q <= 1'b0;
    end else if (fetch_now) begin
      lpc_q       <= lpc_q + 1'b1;
      pend_addr_q <= lpc_q;
      pend_q      <= !mode_chg;
    end else begin
      pend_q <= 1'b0;
    end
  end

  // R10
  no_pend_in_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> mode_q);

  // R11
  standby_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !pend_q);

  // R9
  jump_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> !pend_q);
endmodule

// File: rtl/node_seq_ctrl.sv
module node_seq_ctrl #(
  parameter int ID_W = 7,
  parameter int PC_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [ID_W-1:0] node_id,
  input  logic        standby,
  input  logic        bcast_valid,
  output logic        bcast_ready,
  input  logic [31:0] bcast_instr,
  output logic        lpm_rd_en,
  output logic [PC_W-1:0] lpm_addr,
  input  logic [31:0] lpm_rdata,
  output logic        issue_valid,
  output logic [31:0] issue_instr,
  output logic        issue_exec,
  output logic        mimd_mode
);
  import node_ctl_pkg::*;

  logic             mode_q, lmask_q, pend_q;
  logic             simd, simd_fire, mimd_issue, mask_hit, exec_now;
  logic [OPC_W-1:0] opc;
  logic             jump_req, cfg_we, cfg_val, msk_we, msk_val, mode_chg;
  logic [PC_W-1:0]  jump_tgt;

  node_mask_eval #(.ID_W(ID_W)) u_mask (
    .id_field  (bcast_instr[ID_W-1:0]),
    .sel_local (bcast_instr[MSEL_BIT]),
    .node_id   (node_id),
    .lmask     (lmask_q),
    .hit       (mask_hit)
  );

  always_comb begin
    simd        = (mode_q == MODE_SIMD);
    bcast_ready = simd && !standby;
    simd_fire   = bcast_valid && bcast_ready;
    mimd_issue  = !simd && !standby && pend_q;
    issue_valid = simd_fire || mimd_issue;
    issue_instr = simd ? bcast_instr : lpm_rdata;
    issue_exec  = issue_valid && (simd ? mask_hit : 1'b1);
    exec_now    = issue_valid && issue_exec;
    opc         = issue_instr[OPC_LSB +: OPC_W];
    jump_req    = exec_now && (opc == OPC_JUMPI);
    jump_tgt    = issue_instr[ARG_LSB +: PC_W];
    cfg_we      = exec_now && (opc == OPC_CONFIG);
    cfg_val     = issue_instr[ARG_LSB];
    msk_we      = exec_now && (opc == OPC_SETMASK);
    msk_val     = issue_instr[ARG_LSB];
    mode_chg    = cfg_we && (cfg_val != mode_q);
    mimd_mode   = mode_q;
  end

  node_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_val (cfg_val),
    .msk_we  (msk_we),
    .msk_val (msk_val),
    .mode_q  (mode_q),
    .lmask_q (lmask_q)
  );

  node_local_fetch #(.PC_W(PC_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .standby   (standby),
    .jump_req  (jump_req),
    .jump_tgt  (jump_tgt),
    .mode_chg  (mode_chg),
    .lpm_rd_en (lpm_rd_en),
    .lpm_addr  (lpm_addr),
    .pend_q    (pend_q)
  );

  // R8
  mimd_always_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && mimd_mode) |-> issue_exec);

  // R11
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!issue_valid && !lpm_rd_en && !bcast_ready));

  // R3
  all_ids_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !mimd_mode && !bcast_instr[MSEL_BIT] &&
     (bcast_instr[ID_W-1:0] == {ID_W{1'b1}})) |-> issue_exec);

  // R2
  fetch_not_in_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_ready |-> !lpm_rd_en);
endmodule

// File: tb/node_seq_ctrl_test.sv
module node_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  node_id = 7'h05;
  logic        standby = 1'b0;
  logic        bcast_valid = 1'b0;
  logic        bcast_ready;
  logic [31:0] bcast_instr = '0;
  logic        lpm_rd_en;
  logic [10:0] lpm_addr;
  logic [31:0] lpm_rdata = '0;
  logic        issue_valid;
  logic [31:0] issue_instr;
  logic        issue_exec;
  logic        mimd_mode;

  int tests = 0;
  int fails = 0;
  logic [31:0] lpm [0:2047];
  logic [31:0] log_q [0:15];
  int          log_n = 0;

  always #10 clk = ~clk;

  node_seq_ctrl uut (.*);

  always @(posedge clk) begin
    if (lpm_rd_en) lpm_rdata <= lpm[lpm_addr];
    if (issue_valid && mimd_mode && log_n < 16) begin
      log_q[log_n] <= issue_instr;
      log_n        <= log_n + 1;
    end
  end

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [10:0] arg,
                                     input logic sel, input logic [6:0] id);
    return {op, 7'd0, arg, sel, id};
  endfunction

  localparam logic [31:0] I_A = {6'h01, 7'd0, 11'h0AA, 1'b0, 7'h00};
  localparam logic [31:0] I_C = {6'h01, 7'd0, 11'h0CC, 1'b0, 7'h00};
  localparam logic [31:0] I_D = {6'h02, 7'd0, 11'h0DD, 1'b0, 7'h00};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, output logic v, output logic e);
    @(negedge clk);
    bcast_valid = 1'b1;
    bcast_instr = ins;
    #2;
    v = issue_valid;
    e = issue_exec;
    @(negedge clk);
    bcast_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 mode", {31'd0, mimd_mode}, 0);
    check("R1 ready", {31'd0, bcast_ready}, 1);
    check("R1 issue", {31'd0, issue_valid}, 0);
    check("R1 rd_en", {31'd0, lpm_rd_en}, 0);
  endtask

  task automatic t_id_mask;
    logic v, e;
    send(mk(6'h01, 0, 0, 7'h05), v, e);
    check("R2 issue same cycle", {31'd0, v}, 1);
    check("R3 own id", {31'd0, e}, 1);
    send(mk(6'h01, 0, 0, 7'h09), v, e);
    check("R3 other id", {31'd0, e}, 0);
    send(mk(6'h01, 0, 0, 7'h7F), v, e);
    check("R3 all ids", {31'd0, e}, 1);
    send(mk(6'h01, 0, 1, 7'h09), v, e);
    check("R1 local mask reset 1", {31'd0, e}, 1);
  endtask

  task automatic t_local_mask;
    logic v, e;
    send(mk(6'h3D, 11'd0, 0, 7'h09), v, e);
    send(mk(6'h01, 0, 1, 7'h00), v, e);
    check("R5 masked setmask ignored", {31'd0, e}, 1);
    send(mk(6'h3D, 11'd0, 0, 7'h05), v, e);
    send(mk(6'h01, 0, 1, 7'h05), v, e);
    check("R4 local mask 0", {31'd0, e}, 0);
    send(mk(6'h3D, 11'd1, 1, 7'h05), v, e);
    check("R4 setmask under local mask 0", {31'd0, e}, 0);
    send(mk(6'h01, 0, 1, 7'h05), v, e);
    check("R5 mask unchanged", {31'd0, e}, 0);
    send(mk(6'h3D, 11'd1, 0, 7'h7F), v, e);
    send(mk(6'h01, 0, 1, 7'h00), v, e);
    check("R4 local mask 1", {31'd0, e}, 1);
  endtask

  task automatic t_masked_cfg;
    logic v, e;
    send(mk(6'h3E, 11'd1, 0, 7'h09), v, e);
    check("R5 masked config exec", {31'd0, e}, 0);
    check("R5 mode kept", {31'd0, mimd_mode}, 0);
    check("R5 ready kept", {31'd0, bcast_ready}, 1);
  endtask

  task automatic enter_mimd(input logic [10:0] tgt);
    logic v, e;
    send(mk(6'h10, tgt, 0, 7'h05), v, e);
    send(mk(6'h3E, 11'd1, 0, 7'h05), v, e);
    log_n = 0;
  endtask

  task automatic wait_simd;
    for (int i = 0; i < 60 && mimd_mode; i++) @(negedge clk);
    #1;
  endtask

  task automatic check_log(input string req);
    check({req, " count"}, log_n, 4);
    check({req, " w0"}, log_q[0], I_A);
    check({req, " w1"}, log_q[1], mk(6'h10, 11'h080, 0, 7'h00));
    check({req, " w2"}, log_q[2], I_D);
    check({req, " w3"}, log_q[3], mk(6'h3E, 11'd0, 0, 7'h00));
  endtask

  task automatic t_mimd_run;
    logic v, e;
    send(mk(6'h3D, 11'd0, 0, 7'h05), v, e);
    enter_mimd(11'h040);
    check("R7 mode next cycle", {31'd0, mimd_mode}, 1);
    check("R2 ready low in MIMD", {31'd0, bcast_ready}, 0);
    check("R8 rd_en", {31'd0, lpm_rd_en}, 1);
    check("R6 fetch at target", {21'd0, lpm_addr}, 32'h40);
    wait_simd();
    check_log("R9 R8 stream");
    check("R10 ready after exit", {31'd0, bcast_ready}, 1);
    check("R10 no fetch", {31'd0, lpm_rd_en}, 0);
    send(mk(6'h01, 0, 1, 7'h05), v, e);
    check("R12 mask kept", {31'd0, e}, 0);
    send(mk(6'h3D, 11'd1, 0, 7'h05), v, e);
  endtask

  task automatic t_standby_simd;
    @(negedge clk);
    bcast_valid = 1'b1;
    bcast_instr = mk(6'h01, 0, 0, 7'h05);
    standby     = 1'b1;
    #2;
    check("R11 ready low", {31'd0, bcast_ready}, 0);
    check("R11 no issue", {31'd0, issue_valid}, 0);
    @(negedge clk);
    standby = 1'b0;
    #2;
    check("R11 held word issued", {31'd0, issue_valid}, 1);
    check("R11 held word", issue_instr, mk(6'h01, 0, 0, 7'h05));
    @(negedge clk);
    bcast_valid = 1'b0;
    #2;
    check("R11 once", {31'd0, issue_valid}, 0);
  endtask

  task automatic t_standby_mimd;
    enter_mimd(11'h040);
    @(negedge clk);
    standby = 1'b1;
    #2;
    check("R11 no MIMD issue", {31'd0, issue_valid}, 0);
    check("R11 no fetch", {31'd0, lpm_rd_en}, 0);
    repeat (3) @(negedge clk);
    standby = 1'b0;
    wait_simd();
    check_log("R11 resume");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) lpm[i] = '0;
    lpm[11'h040] = I_A;
    lpm[11'h041] = mk(6'h10, 11'h080, 0, 7'h00);
    lpm[11'h042] = I_C;
    lpm[11'h080] = I_D;
    lpm[11'h081] = mk(6'h3E, 11'd0, 0, 7'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_mask();
    t_local_mask();
    t_masked_cfg();
    t_mimd_run();
    t_standby_simd();
    t_standby_mimd();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule